// File: doc/BRIEF.md
# Selectable Output Clock Divider Bank

This block takes one fast input clock and derives three output clocks from two dividers. Divider A drives a single output. Divider B drives a group of outputs that always share one phase and one frequency. Each divider reads its own 2-bit ratio select. An active-low bypass input overrides both selects and passes the input clock through at its own rate. Every output has its own enable, and a disabled output is held at logic 0. The active-low power-on reset puts both dividers into a common alignment state. As a result, outputs with equal ratios leave reset in phase.

Each divider is a three-state machine. The states are DV_ALIGN, DV_RUN and DV_LAST:

- DV_ALIGN is the state held during reset. Its only transition, "align-to-start", is taken on the first rising input edge after reset is released.
- DV_RUN covers the input cycles inside one output period. It has two transitions: "count" stays in DV_RUN, and "approach-end" moves to DV_LAST when the next cycle is the last one of the period.
- DV_LAST is the final input cycle of a period. On the next rising edge it takes "wrap-to-run", or "wrap-to-last" when the new ratio is 1.

The ratio and the enables are sampled only on leaving DV_ALIGN or DV_LAST. Each output stage has one flop on the rising edge and one on the falling edge, and the output is the XOR of the two. This lets an output follow a per-half-cycle level pattern, which gives a 50% duty cycle for the odd ratio and an exact copy of the input clock in bypass.

Top module: `cdb_bank`

## Requirements
- R1: The select code sets the output period in input clock cycles: code 2'b00 gives 10, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 5.
- R2: Every output is high for exactly N input half-cycles and then low for N half-cycles, where N is the active ratio. This includes the ratio of 5.
- R3: While byp_n is 0, both dividers use a ratio of 1 whatever their selects say. Each enabled output is then high for one half-cycle and low for one half-cycle.
- R4: Divider A takes its ratio only from sel_a, and divider B takes its ratio only from sel_b.
- R5: While all B outputs are enabled, they are equal at every sample.
- R6: A disabled output stays at constant 0. Disabling one B output does not affect the other B outputs.
- R7: A new select or bypass value is taken only at a period boundary. The period in progress completes with the old ratio.
- R8: An enable change takes effect only at a period boundary. A high phase in progress completes in full, and a re-enabled output rejoins in phase with its divider.
- R9: While por_n is 0, all outputs are 0. After release, both dividers start a period on the same first rising edge, so outputs with equal ratios are in phase.
- R10: Every output is low in the half-cycle before each period boundary. Ratio changes, including leaving bypass, therefore produce no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| byp_n | input | 1 | Bypass, active low; forces ratio 1 on both dividers |
| sel_a | input | 2 | Ratio select for divider A |
| sel_b | input | 2 | Ratio select for divider B |
| en_a | input | 1 | Enable for the A output |
| en_b | input | B_OUTS | Per-output enables for the B group |
| clk_a | output | 1 | Divided clock from divider A |
| clk_b | output | B_OUTS | Divided clocks from divider B, phase-aligned |

## Verification
The bound checker verifies on every rising edge the properties that hold cycle by cycle:

- the ratio decode at a boundary, and the bypass override;
- that ratios and enables hold steady between boundaries;
- that outputs are low when a boundary is reached;
- that disabled outputs are low;
- that the B group outputs are equal.

Other behaviours show only over whole periods, so only the bench scenarios can demonstrate them. These are the measured high and low run lengths for each code and in bypass, the completion of an interrupted period with its old ratio, a high phase that finishes after its enable drops, and phase agreement between A and B after reset.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    // Ratio select encodings
    typedef enum logic [1:0] {
        SEL_DIV10 = 2'b00,
        SEL_DIV2  = 2'b01,
        SEL_DIV4  = 2'b10,
        SEL_DIV5  = 2'b11
    } sel_code_e;

    // Divider sequencing states
    typedef enum logic [1:0] {
        DV_ALIGN = 2'b00,
        DV_RUN   = 2'b01,
        DV_LAST  = 2'b10
    } div_state_e;

    // Ratio in input cycles for a select code; bypass (active low) forces 1
    function automatic int ratio_for(input logic [1:0] sel, input logic byp_n);
        int r;
        if (!byp_n) begin
            r = 1;
        end else begin
            unique case (sel_code_e'(sel))
                SEL_DIV10: r = 10;
                SEL_DIV2:  r = 2;
                SEL_DIV4:  r = 4;
                SEL_DIV5:  r = 5;
                default:   r = 10;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cdb_divider.sv
module cdb_divider
    import cdb_pkg::*;
#(
    parameter int CNT_W = 4
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byp_n,
    input  logic [1:0]       sel,
    output logic             bnd,
    output logic             hi_rise,
    output logic             hi_fall,
    output logic [CNT_W-1:0] ratio_act
);

    localparam int HALF_W = CNT_W + 1;
    typedef logic [CNT_W-1:0] cnt_t;

    div_state_e st_q, st_d;
    cnt_t       cnt_q, cnt_d;
    cnt_t       ratio_q, ratio_d;
    cnt_t       ratio_req;

    assign ratio_req = CNT_W'(ratio_for(sel, byp_n));

    // Next-state and datapath for the period sequencer
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        unique case (st_q)
            DV_ALIGN, DV_LAST: begin
                // align-to-start / wrap-to-run / wrap-to-last
                ratio_d = ratio_req;
                cnt_d   = '0;
                st_d    = (ratio_req == cnt_t'(1)) ? DV_LAST : DV_RUN;
            end
            DV_RUN: begin
                // count / approach-end
                cnt_d = cnt_q + 1'b1;
                st_d  = (cnt_d == ratio_q - 1'b1) ? DV_LAST : DV_RUN;
            end
            default: begin
                st_d  = DV_ALIGN;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= DV_ALIGN;
            cnt_q   <= '0;
            ratio_q <= cnt_t'(1);
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // Outputs: half-cycle level targets for the two edge domains
    always_comb begin
        bnd       = (st_q == DV_ALIGN) || (st_q == DV_LAST);
        hi_rise   = HALF_W'({cnt_d, 1'b0}) < HALF_W'({1'b0, ratio_d});
        hi_fall   = (st_q != DV_ALIGN) &&
                    (HALF_W'({cnt_q, 1'b1}) < HALF_W'({1'b0, ratio_q}));
        ratio_act = ratio_q;
    end

endmodule

// File: rtl/cdb_edge_out.sv
module cdb_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd,
    input  logic hi_rise,
    input  logic hi_fall,
    input  logic en,
    output logic clk_out,
    output logic en_act
);

    logic rise_q;
    logic fall_q;
    logic en_q;
    logic en_nxt;

    // Enable is only taken at a period boundary
    assign en_nxt = bnd ? en : en_q;

    // Rising-edge half: output becomes hi_rise & enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            en_q   <= en_nxt;
            rise_q <= (hi_rise & en_nxt) ^ fall_q;
        end
    end

    // Falling-edge half: output becomes hi_fall & enable
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= (hi_fall & en_q) ^ rise_q;
        end
    end

    assign clk_out = rise_q ^ fall_q;
    assign en_act  = en_q;

endmodule

// File: rtl/cdb_bank.sv
module cdb_bank #(
    parameter int B_OUTS = 2,
    parameter int CNT_W  = 4
)
(
    input  logic              clk_in,
    input  logic              por_n,
    input  logic              byp_n,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic              en_a,
    input  logic [B_OUTS-1:0] en_b,
    output logic              clk_a,
    output logic [B_OUTS-1:0] clk_b
);

    logic             bnd_a, bnd_b;
    logic             rise_a, rise_b;
    logic             fall_a, fall_b;
    logic [CNT_W-1:0] ratio_a, ratio_b;
    logic             en_act_a;
    logic [B_OUTS-1:0] en_act_b;

    cdb_divider #(.CNT_W(CNT_W)) u_div_a (
        .clk       (clk_in),
        .rst_n     (por_n),
        .byp_n     (byp_n),
        .sel       (sel_a),
        .bnd       (bnd_a),
        .hi_rise   (rise_a),
        .hi_fall   (fall_a),
        .ratio_act (ratio_a)
    );

    cdb_divider #(.CNT_W(CNT_W)) u_div_b (
        .clk       (clk_in),
        .rst_n     (por_n),
        .byp_n     (byp_n),
        .sel       (sel_b),
        .bnd       (bnd_b),
        .hi_rise   (rise_b),
        .hi_fall   (fall_b),
        .ratio_act (ratio_b)
    );

    cdb_edge_out u_out_a (
        .clk     (clk_in),
        .rst_n   (por_n),
        .bnd     (bnd_a),
        .hi_rise (rise_a),
        .hi_fall (fall_a),
        .en      (en_a),
        .clk_out (clk_a),
        .en_act  (en_act_a)
    );

    for (genvar gi = 0; gi < B_OUTS; gi++) begin : g_b_out
        cdb_edge_out u_out_b (
            .clk     (clk_in),
            .rst_n   (por_n),
            .bnd     (bnd_b),
            .hi_rise (rise_b),
            .hi_fall (fall_b),
            .en      (en_b[gi]),
            .clk_out (clk_b[gi]),
            .en_act  (en_act_b[gi])
        );
    end

endmodule

// File: rtl/cdb_bank_chk.sv
module cdb_bank_chk #(
    parameter int B_OUTS = 2,
    parameter int CNT_W  = 4
)
(
    input  logic              clk_in,
    input  logic              por_n,
    input  logic              byp_n,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic              clk_a,
    input  logic [B_OUTS-1:0] clk_b,
    input  logic              bnd_a,
    input  logic              bnd_b,
    input  logic [CNT_W-1:0]  ratio_a,
    input  logic [CNT_W-1:0]  ratio_b,
    input  logic              en_act_a,
    input  logic [B_OUTS-1:0] en_act_b
);

    // R1
    sel_a_div10_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        (bnd_a && byp_n && sel_a == 2'b00) |=> ratio_a == CNT_W'(10));

    // R1
    sel_b_div5_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        (bnd_b && byp_n && sel_b == 2'b11) |=> ratio_b == CNT_W'(5));

    // R3
    bypass_a_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        (bnd_a && !byp_n) |=> ratio_a == CNT_W'(1));

    // R3
    bypass_b_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        (bnd_b && !byp_n) |=> ratio_b == CNT_W'(1));

    // R7
    ratio_a_hold_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        !bnd_a |=> $stable(ratio_a));

    // R7
    ratio_b_hold_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        !bnd_b |=> $stable(ratio_b));

    // R8
    en_a_hold_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        !bnd_a |=> $stable(en_act_a));

    // R8
    en_b_hold_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        !bnd_b |=> $stable(en_act_b));

    // R10
    low_at_bnd_a_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        bnd_a |-> !clk_a);

    // R10
    low_at_bnd_b_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        bnd_b |-> $countones(clk_b) == 0);

    // R6
    off_a_low_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        !en_act_a |-> !clk_a);

    // R5
    b_group_equal_chk: assert property (@(posedge clk_in) disable iff (!por_n)
        (en_act_b == {B_OUTS{1'b1}}) |-> (clk_b == {B_OUTS{clk_b[0]}}));

endmodule

bind cdb_bank cdb_bank_chk #(.B_OUTS(B_OUTS), .CNT_W(CNT_W)) u_chk (
    .clk_in   (clk_in),
    .por_n    (por_n),
    .byp_n    (byp_n),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .bnd_a    (bnd_a),
    .bnd_b    (bnd_b),
    .ratio_a  (ratio_a),
    .ratio_b  (ratio_b),
    .en_act_a (en_act_a),
    .en_act_b (en_act_b)
);

// File: tb/sim_cdb_bank.sv
module sim_cdb_bank;

    localparam int B_OUTS = 2;

    logic              clk_in = 1'b0;
    logic              por_n  = 1'b1;
    logic              byp_n  = 1'b1;
    logic [1:0]        sel_a  = 2'b00;
    logic [1:0]        sel_b  = 2'b00;
    logic              en_a   = 1'b1;
    logic [B_OUTS-1:0] en_b   = '1;
    logic              clk_a;
    logic [B_OUTS-1:0] clk_b;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [2:0] smp  = '0;
    logic [2:0] prev = '0;
    int    run_hi [3];
    int    run_lo [3];
    int    q0 [$];
    int    q1 [$];
    int    q2 [$];
    string t0 [$];
    string t1 [$];
    string t2 [$];
    int    pend = 0;
    bit    align_on = 1'b0;
    int    align_bad = 0;
    event  smp_ev;
    event  rise_a_ev;
    event  rise_b1_ev;

    // 125 MHz: 8 ns period
    always #4 clk_in = ~clk_in;

    cdb_bank #(.B_OUTS(B_OUTS)) u0 (
        .clk_in (clk_in),
        .por_n  (por_n),
        .byp_n  (byp_n),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .en_a   (en_a),
        .en_b   (en_b),
        .clk_a  (clk_a),
        .clk_b  (clk_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ratio per select code, from R1
    function automatic int div_of(input logic [1:0] code);
        case (code)
            2'b00:   return 10;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 5;
        endcase
    endfunction

    // Driver side: push an expected period (high N, low N half-cycles)
    task automatic expect_period(input int idx, input int n, input string tg);
        pend++;
        case (idx)
            0:       begin q0.push_back(n * 100 + n); t0.push_back(tg); end
            1:       begin q1.push_back(n * 100 + n); t1.push_back(tg); end
            default: begin q2.push_back(n * 100 + n); t2.push_back(tg); end
        endcase
    endtask

    // Monitor side: compare a measured period against the queue head
    task automatic finish_period(input int idx, input int h, input int l);
        int    e;
        string tg;
        bit    got;
        got = 1'b0;
        e   = 0;
        case (idx)
            0: if (q0.size() > 0) begin e = q0.pop_front(); tg = t0.pop_front(); got = 1'b1; end
            1: if (q1.size() > 0) begin e = q1.pop_front(); tg = t1.pop_front(); got = 1'b1; end
            default: if (q2.size() > 0) begin e = q2.pop_front(); tg = t2.pop_front(); got = 1'b1; end
        endcase
        if (got) begin
            pend--;
            check(h * 100 + l == e, tg, h * 100 + l, e);
        end
    endtask

    // Sample every half-cycle, 2 ns after each edge
    always @(clk_in) begin
        #2;
        smp = {clk_b[1], clk_b[0], clk_a};
        for (int i = 0; i < 3; i++) begin
            if (smp[i] && !prev[i]) begin
                if (run_hi[i] > 0 && run_lo[i] > 0) finish_period(i, run_hi[i], run_lo[i]);
                run_hi[i] = 1;
                run_lo[i] = 0;
                if (i == 0) -> rise_a_ev;
                if (i == 2) -> rise_b1_ev;
            end else if (smp[i]) begin
                run_hi[i]++;
            end else begin
                run_lo[i]++;
            end
        end
        if (align_on && smp[1] != smp[2]) align_bad++;
        prev = smp;
        -> smp_ev;
    end

    task automatic half(input int n);
        repeat (n) @(smp_ev);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        int mism;
        int highs;
        int bad;

        // R9: reset holds outputs low
        #1 por_n = 1'b0;
        sel_a = 2'b11;
        sel_b = 2'b11;
        half(5);
        check(clk_a == 1'b0, "R9", int'(clk_a), 0);
        check(clk_b == '0, "R9", int'(clk_b), 0);
        por_n = 1'b1;

        // R9: equal ratios leave reset in phase
        mism = 0;
        highs = 0;
        for (int k = 0; k < 40; k++) begin
            half(1);
            if (clk_a != clk_b[0]) mism++;
            if (clk_a) highs++;
        end
        check(mism == 0, "R9", mism, 0);
        check(highs == 20, "R9", highs, 20);

        // R1, R2, R4, R5: sweep codes, A and B on different codes
        align_on = 1'b1;
        for (int code = 0; code < 4; code++) begin
            sel_a = 2'(code);
            sel_b = 2'(code + 1);
            half(60);
            expect_period(0, div_of(2'(code)), "R1");
            expect_period(0, div_of(2'(code)), "R2");
            expect_period(1, div_of(2'(code + 1)), "R4");
            expect_period(1, div_of(2'(code + 1)), "R2");
            expect_period(2, div_of(2'(code + 1)), "R4");
            expect_period(2, div_of(2'(code + 1)), "R2");
            wait (pend == 0);
        end

        // R3: bypass forces ratio 1 regardless of selects
        byp_n = 1'b0;
        half(40);
        for (int k = 0; k < 3; k++) expect_period(k, 1, "R3");
        for (int k = 0; k < 3; k++) expect_period(k, 1, "R3");
        wait (pend == 0);

        // R10: leaving bypass mid-stream, no runt pulse
        sel_a = 2'b11;
        @(rise_a_ev);
        expect_period(0, 1, "R10");
        expect_period(0, 5, "R10");
        expect_period(0, 5, "R10");
        byp_n = 1'b1;
        wait (pend == 0);
        check(align_bad == 0, "R5", align_bad, 0);

        // R7: select change inside a period finishes the old period
        sel_a = 2'b00;
        half(60);
        @(rise_a_ev);
        expect_period(0, 10, "R7");
        expect_period(0, 2, "R7");
        expect_period(0, 2, "R7");
        sel_a = 2'b01;
        wait (pend == 0);

        // R8: disabling a B output just after it rises keeps the pulse whole
        align_on = 1'b0;
        sel_b = 2'b11;
        half(40);
        @(rise_b1_ev);
        en_b[1] = 1'b0;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            half(1);
            if (!clk_b[1]) bad++;
        end
        check(bad == 0, "R8", bad, 0);

        // R6: disabled B output stays low, sibling keeps running
        half(1);
        bad = 0;
        highs = 0;
        for (int k = 0; k < 30; k++) begin
            half(1);
            if (clk_b[1]) bad++;
            if (clk_b[0]) highs++;
        end
        check(bad == 0, "R6", bad, 0);
        check(highs == 15, "R6", highs, 15);

        // R8: re-enabled output rejoins in phase
        en_b[1] = 1'b1;
        half(30);
        mism = 0;
        for (int k = 0; k < 40; k++) begin
            half(1);
            if (clk_b[0] != clk_b[1]) mism++;
        end
        check(mism == 0, "R8", mism, 0);

        // R6: disabled A output stays low
        en_a = 1'b0;
        half(30);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            half(1);
            if (clk_a) bad++;
        end
        check(bad == 0, "R6", bad, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", pend, 0);
            summary();
            $finish;
        end
    end

endmodule